// File: doc/BRIEF.md
# Delayed Read Admission Tracker

This block sits at the target side of a bus bridge. It decides, for each read request a master presents, whether the request may open a delayed read with prefetch, or whether it must be retried. It keeps a small table of outstanding delayed-read slots. Each slot holds the requesting master's identifier, the address and the command code of the read it tracks.

When a master returns with exactly the same identifier, address and command as a live slot, the tracker reports a reconnection hit on that slot. A hit opens nothing new. A request that does not hit may open a fresh slot, but only under two limits. The first is a programmable cap on how many slots may be live at once. The second is an optional rule that lets each master hold at most one slot. A request that would break either limit is answered with a retry.

Slots are returned to the free pool by a release pulse, which the completion or discard logic drives with the slot index. Data buffering and prefetch timing are handled elsewhere.

Top module: `dread_admit`

## Requirements
- R1: While `rst` is high, all four response flags read 0 and both index outputs read 0. After `rst` falls, every slot is empty, so the first request that is not a hit is given slot 0.
- R2: A request whose master, address and command all equal those of a live slot is answered with `rsp_accept`=1, `rsp_hit`=1 and `rsp_hit_idx` set to that slot. It opens no slot. A hit is accepted even when the cap is 0 or the master already holds a slot.
- R3: An accepted request that is not a hit is given the free slot with the lowest index, and that index is reported on `rsp_alloc_idx`.
- R4: The effective cap is `cfg_limit`, clamped to NUM_SLOTS when `cfg_limit` is larger. A non-hit request that arrives while the number of live slots is at or above the cap is retried. A cap of 0 retries every non-hit request.
- R5: While `cfg_one_per_master` is 1, a non-hit request from a master that already holds a live slot is retried. While it is 0, such a request is admitted subject to R4.
- R6: A retried request opens no slot. `rsp_retry` is 1, `rsp_accept` and `rsp_hit` are 0, and both index outputs read 0.
- R7: A `rel_valid` pulse empties slot `rel_index` at that clock edge. A request presented in the same cycle as the pulse still sees the slot as live. From the next cycle on, the slot is free.
- R8: Each request is answered exactly one clock after it is presented. In that answer, exactly one of `rsp_accept` and `rsp_retry` is 1. In a cycle that answers no request, all response flags are 0. `rsp_alloc_idx` reads 0 unless a slot was opened, and `rsp_hit_idx` reads 0 unless the answer is a hit.
- R9: A release pulse that names an empty slot changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A read request is presented this cycle |
| req_master | input | MID_W | Identifier of the requesting master |
| req_addr | input | ADDR_W | Read address |
| req_cmd | input | CMD_W | Read command code |
| rel_valid | input | 1 | Release pulse for one slot |
| rel_index | input | IDX_W | Slot freed by the release pulse |
| cfg_limit | input | CNT_W | Cap on live slots (clamped to NUM_SLOTS) |
| cfg_one_per_master | input | 1 | Allow at most one live slot per master |
| rsp_valid | output | 1 | A response is presented |
| rsp_accept | output | 1 | Request accepted (new slot or hit) |
| rsp_retry | output | 1 | Request must be retried |
| rsp_hit | output | 1 | Request matched a live slot |
| rsp_alloc_idx | output | IDX_W | Slot opened for the request |
| rsp_hit_idx | output | IDX_W | Slot the request matched |

## Verification
Every response is due in the cycle that follows its request. A release takes effect at the same edge, but only requests presented after that edge can see it. The bench drives inputs on the falling edge. At the rising edge, a behavioural model takes the same inputs, updates its own slot list and produces the expected response. The bench then compares all six outputs one time unit after that edge, which is exactly where the registered answer appears. Releases issued in the same cycle as a request are included, to confirm that the request is judged against the slot list as it stood before the release.

// File: rtl/dra_pkg.sv
package dra_pkg;
  typedef enum logic [1:0] {
    VERDICT_NONE  = 2'd0,
    VERDICT_ALLOC = 2'd1,
    VERDICT_HIT   = 2'd2,
    VERDICT_RETRY = 2'd3
  } verdict_t;
endpackage

// File: rtl/dra_slot_table.sv
module dra_slot_table #(
  parameter int NUM_SLOTS = 8,
  parameter int MID_W     = 4,
  parameter int TAG_W     = 40,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [TAG_W-1:0]     wr_tag,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  input  logic [TAG_W-1:0]     probe_tag,
  output logic [NUM_SLOTS-1:0] live_vec,
  output logic [NUM_SLOTS-1:0] match_vec,
  output logic [NUM_SLOTS-1:0] owner_vec
);
  // The master identifier occupies the top MID_W bits of each tag.
  logic [TAG_W-1:0] tag_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        live_vec[s] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(s)) begin
        live_vec[s] <= 1'b1;
      end else if (clr_en && clr_idx == IDX_W'(s)) begin
        live_vec[s] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(s)) tag_q[s] <= wr_tag;
    end

    assign match_vec[s] = live_vec[s] && (tag_q[s] == probe_tag);
    assign owner_vec[s] = live_vec[s] &&
      (tag_q[s][TAG_W-1 -: MID_W] == probe_tag[TAG_W-1 -: MID_W]);
  end
endmodule

// File: rtl/dra_first_set.sv
module dra_first_set #(
  parameter int N      = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign found = |vec;
endmodule

// File: rtl/dra_popcount.sv
module dra_popcount #(
  parameter int N      = 8,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     vec,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + CNT_W'(vec[i]);
  end
endmodule

// File: rtl/dread_admit.sv
module dread_admit #(
  parameter int NUM_SLOTS = 8,
  parameter int MID_W     = 4,
  parameter int ADDR_W    = 32,
  parameter int CMD_W     = 4,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [MID_W-1:0]  req_master,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic              rel_valid,
  input  logic [IDX_W-1:0]  rel_index,
  input  logic [CNT_W-1:0]  cfg_limit,
  input  logic              cfg_one_per_master,
  output logic              rsp_valid,
  output logic              rsp_accept,
  output logic              rsp_retry,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_alloc_idx,
  output logic [IDX_W-1:0]  rsp_hit_idx
);
  import dra_pkg::*;

  localparam int TAG_W = MID_W + ADDR_W + CMD_W;

  logic [TAG_W-1:0]     req_tag;
  logic [NUM_SLOTS-1:0] live_vec, match_vec, owner_vec;
  logic                 hit_found, free_found;
  logic [IDX_W-1:0]     hit_idx, free_idx;
  logic [CNT_W-1:0]     live_cnt, cap;
  logic                 over_cap, owner_busy;
  verdict_t             verdict;

  assign req_tag = {req_master, req_addr, req_cmd};

  dra_slot_table #(.NUM_SLOTS(NUM_SLOTS), .MID_W(MID_W), .TAG_W(TAG_W)) u_table (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (verdict == VERDICT_ALLOC),
    .wr_idx    (free_idx),
    .wr_tag    (req_tag),
    .clr_en    (rel_valid),
    .clr_idx   (rel_index),
    .probe_tag (req_tag),
    .live_vec  (live_vec),
    .match_vec (match_vec),
    .owner_vec (owner_vec)
  );

  dra_first_set #(.N(NUM_SLOTS)) u_hit_pick (
    .vec (match_vec), .found (hit_found), .idx (hit_idx)
  );

  dra_first_set #(.N(NUM_SLOTS)) u_free_pick (
    .vec (~live_vec), .found (free_found), .idx (free_idx)
  );

  dra_popcount #(.N(NUM_SLOTS)) u_count (
    .vec (live_vec), .count (live_cnt)
  );

  assign cap        = (cfg_limit > CNT_W'(NUM_SLOTS)) ? CNT_W'(NUM_SLOTS) : cfg_limit;
  assign over_cap   = (live_cnt >= cap) || !free_found;
  assign owner_busy = cfg_one_per_master && (|owner_vec);

  always_comb begin
    if (!req_valid)              verdict = VERDICT_NONE;
    else if (hit_found)          verdict = VERDICT_HIT;
    else if (over_cap || owner_busy) verdict = VERDICT_RETRY;
    else                         verdict = VERDICT_ALLOC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_accept    <= 1'b0;
      rsp_retry     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_alloc_idx <= '0;
      rsp_hit_idx   <= '0;
    end else begin
      rsp_valid     <= verdict != VERDICT_NONE;
      rsp_accept    <= (verdict == VERDICT_ALLOC) || (verdict == VERDICT_HIT);
      rsp_retry     <= verdict == VERDICT_RETRY;
      rsp_hit       <= verdict == VERDICT_HIT;
      rsp_alloc_idx <= (verdict == VERDICT_ALLOC) ? free_idx : '0;
      rsp_hit_idx   <= (verdict == VERDICT_HIT) ? hit_idx : '0;
    end
  end
endmodule

// File: rtl/dread_admit_chk.sv
module dread_admit_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int MID_W     = 4,
  parameter int ADDR_W    = 32,
  parameter int CMD_W     = 4,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [MID_W-1:0]  req_master,
  input logic [ADDR_W-1:0] req_addr,
  input logic [CMD_W-1:0]  req_cmd,
  input logic              rel_valid,
  input logic [IDX_W-1:0]  rel_index,
  input logic [CNT_W-1:0]  cfg_limit,
  input logic              cfg_one_per_master,
  input logic              rsp_valid,
  input logic              rsp_accept,
  input logic              rsp_retry,
  input logic              rsp_hit,
  input logic [IDX_W-1:0]  rsp_alloc_idx,
  input logic [IDX_W-1:0]  rsp_hit_idx
);
  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_accept, rsp_retry}) == 1);

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_accept || rsp_retry || rsp_hit));

  assert_answer_next_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_hit_is_accept_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_accept);

  assert_zero_cap_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cfg_limit == '0) |=> !(rsp_accept && !rsp_hit));

  assert_retry_clean_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_retry |-> (!rsp_hit && rsp_alloc_idx == '0 && rsp_hit_idx == '0));
endmodule

bind dread_admit dread_admit_chk #(
  .NUM_SLOTS(NUM_SLOTS), .MID_W(MID_W), .ADDR_W(ADDR_W), .CMD_W(CMD_W)
) u_chk (.*);

// File: tb/sim_dread_admit.sv
module sim_dread_admit;
  localparam int CLK_PERIOD = 10;
  localparam int N      = 8;
  localparam int MID_W  = 4;
  localparam int ADDR_W = 32;
  localparam int CMD_W  = 4;
  localparam int IDX_W  = $clog2(N);
  localparam int CNT_W  = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [MID_W-1:0]  req_master = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CMD_W-1:0]  req_cmd = '0;
  logic rel_valid = 1'b0;
  logic [IDX_W-1:0]  rel_index = '0;
  logic [CNT_W-1:0]  cfg_limit = CNT_W'(N);
  logic cfg_one_per_master = 1'b0;
  logic rsp_valid, rsp_accept, rsp_retry, rsp_hit;
  logic [IDX_W-1:0] rsp_alloc_idx, rsp_hit_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model of the slot list
  bit m_live [N];
  int m_mid  [N];
  longint m_addr [N];
  int m_cmd  [N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dread_admit #(.NUM_SLOTS(N), .MID_W(MID_W), .ADDR_W(ADDR_W), .CMD_W(CMD_W)) u0 (.*);

  task automatic cmp(string tag, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, name, act, exp);
    end
  endtask

  task automatic step(string tag, bit rv, int m, longint a, int c, bit relv, int reli);
    bit e_val, e_acc, e_ret, e_hit, alloc;
    int e_ai, e_hi, cnt, lim;
    bit busy;
    @(negedge clk);
    req_valid = rv; req_master = MID_W'(m); req_addr = ADDR_W'(a); req_cmd = CMD_W'(c);
    rel_valid = relv; rel_index = IDX_W'(reli);
    @(posedge clk);
    e_val = rv; e_acc = 0; e_ret = 0; e_hit = 0; e_ai = 0; e_hi = 0; alloc = 0;
    if (rv) begin
      for (int i = N - 1; i >= 0; i--)
        if (m_live[i] && m_mid[i] == m && m_addr[i] == a && m_cmd[i] == c) begin
          e_hit = 1; e_hi = i;
        end
      if (e_hit) e_acc = 1;
      else begin
        cnt = 0; busy = 0;
        for (int i = 0; i < N; i++) begin
          if (m_live[i]) cnt++;
          if (m_live[i] && m_mid[i] == m) busy = 1;
        end
        lim = (int'(cfg_limit) > N) ? N : int'(cfg_limit);
        if (cnt >= lim || (cfg_one_per_master && busy)) e_ret = 1;
        else begin
          e_acc = 1; alloc = 1;
          for (int i = N - 1; i >= 0; i--) if (!m_live[i]) e_ai = i;
        end
      end
    end
    if (relv) m_live[reli] = 0;
    if (alloc) begin
      m_live[e_ai] = 1; m_mid[e_ai] = m; m_addr[e_ai] = a; m_cmd[e_ai] = c;
    end
    #1;
    cmp(tag, "rsp_valid", int'(rsp_valid), int'(e_val));
    cmp(tag, "rsp_accept", int'(rsp_accept), int'(e_acc));
    cmp(tag, "rsp_retry", int'(rsp_retry), int'(e_ret));
    cmp(tag, "rsp_hit", int'(rsp_hit), int'(e_hit));
    cmp(tag, "rsp_alloc_idx", int'(rsp_alloc_idx), e_ai);
    cmp(tag, "rsp_hit_idx", int'(rsp_hit_idx), e_hi);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) m_live[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs are all zero while reset is held
    cmp("R1", "rsp_valid", int'(rsp_valid), 0);
    cmp("R1", "rsp_accept", int'(rsp_accept), 0);
    cmp("R1", "rsp_retry", int'(rsp_retry), 0);
    cmp("R1", "rsp_hit", int'(rsp_hit), 0);
    cmp("R1", "rsp_alloc_idx", int'(rsp_alloc_idx), 0);
    @(negedge clk) rst = 0;

    step("R8", 0, 0, 0, 0, 0, 0);
    step("R1", 1, 1, 'h100, 6, 0, 0);          // first request takes slot 0
    step("R3", 1, 2, 'h200, 6, 0, 0);
    step("R3", 1, 3, 'h300, 14, 0, 0);
    step("R2", 1, 2, 'h200, 6, 0, 0);          // reconnection hit on slot 1
    step("R8", 0, 0, 0, 0, 0, 0);
    cfg_one_per_master = 1;
    step("R5", 1, 2, 'h240, 6, 0, 0);          // master 2 busy -> retry
    step("R2", 1, 2, 'h200, 6, 0, 0);          // hit still accepted
    cfg_one_per_master = 0;
    step("R5", 1, 2, 'h240, 6, 0, 0);          // now admitted to slot 3
    step("R7", 0, 0, 0, 0, 1, 1);              // release slot 1
    step("R7", 1, 4, 'h400, 12, 0, 0);         // reuses slot 1
    step("R9", 0, 0, 0, 0, 1, 6);              // release of empty slot
    step("R9", 1, 5, 'h500, 12, 0, 0);         // goes to slot 4
    cfg_limit = CNT_W'(2);
    step("R4", 1, 6, 'h600, 14, 0, 0);         // 5 live >= 2 -> retry
    step("R6", 1, 6, 'h600, 14, 0, 0);         // still retried, nothing opened
    cfg_limit = CNT_W'(0);
    step("R4", 1, 7, 'h700, 6, 0, 0);
    step("R2", 1, 5, 'h500, 12, 0, 0);         // hit ignores zero cap
    cfg_limit = CNT_W'(15);
    step("R4", 1, 6, 'h600, 14, 0, 0);         // clamp to 8 -> slot 5
    step("R3", 1, 7, 'h700, 6, 0, 0);
    step("R3", 1, 8, 'h800, 6, 0, 0);          // table full
    step("R4", 1, 9, 'h900, 6, 0, 0);          // ninth -> retry
    step("R7", 1, 9, 'h900, 6, 1, 2);          // release same cycle: still retry
    step("R7", 1, 9, 'h900, 6, 0, 0);          // slot 2 now free
    step("R7", 1, 9, 'h900, 6, 1, 2);          // hit on slot being released
    step("R7", 1, 9, 'h900, 6, 0, 0);          // reopens slot 2
    for (int k = 0; k < N; k++) step("R7", 0, 0, 0, 0, 1, k);
    step("R3", 1, 10, 'hA00, 6, 0, 0);         // back to slot 0
    step("R8", 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule